// File: doc/BRIEF.md
# TDM Receive System Bus Serializer

This block turns per-timeslot received line data into the serial streams of a time-division multiplexed system bus. Each timeslot the block asks for one PCM byte and one 4-bit ABCD signaling nibble. It names the timeslot it wants and raises a load strobe. It takes the pair on the slot's first bit clock. It then sends the PCM byte out most significant bit first, eight bits per slot. In parallel it sends the signaling nibble twice over the same eight bit times, in the order A, B, C, D, A, B, C, D.

Alongside the data it drives three position markers: a frame marker, a multiframe marker and a timeslot marker. Position counters in the block track the bit, the timeslot and the frame. A frame holds 32 timeslots, and the multiframe spans 48 frames.

A freeze request holds the signaling. For each slot that begins while the request is high, the block replays that slot's last live nibble from a small per-slot store and flags the slot as frozen. A configuration input picks which clock edge launches the two serial data outputs. The rising edge is the default. The falling edge delays them by half a clock.

Top module: `tdm_rx_serializer`

## Requirements
- R1: While `rst` is high, every output that marks position or freeze (`fs_o`, `mfs_o`, `ts_ind_o`, `sig_frz_o`) is low after the next rising clock edge, and the serial data outputs are low as well.
- R2: For each timeslot, `slot_load_o` is high and `slot_req_o` gives the slot index in the cycle before the slot's first bit edge. `ts_pcm` is captured on that edge. `pcm_o` then carries `ts_pcm[7]` first and `ts_pcm[0]` last, one bit per clock.
- R3: `ts_ind_o` is high for exactly the first bit clock of every timeslot and low for the other seven.
- R4: `fs_o` is high for one clock, during the first bit of timeslot 0, once every 256 clocks.
- R5: `mfs_o` is high only together with `fs_o` in frame 1 (the first frame), so it recurs every 48 frames (12288 clocks).
- R6: Outside freeze, `sig_o` carries the nibble captured with the slot: bit 3 (A), bit 2 (B), bit 1 (C), bit 0 (D), and then the same four again.
- R7: `freeze_in` is sampled only on a slot's first bit edge. If it is high there, that slot's `sig_o` replays the nibble last captured live for the same slot index, and the store keeps that old value. A change of `freeze_in` in the middle of a slot has no effect on that slot.
- R8: `sig_frz_o` is high for exactly the slots whose signaling is replayed and stays constant within a slot.
- R9: With `cfg_fall_edge` high, `pcm_o` and `sig_o` change on the falling clock edge and so lag their rising-edge values by half a clock. The position markers and `sig_frz_o` are unaffected.
- R10: After reset is released, the first rising edge starts frame 1, timeslot 0, bit 1, so `fs_o`, `mfs_o` and `ts_ind_o` are all high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fall_edge | input | 1 | 1: data outputs launched on falling edge |
| freeze_in | input | 1 | Signaling freeze request, sampled per slot |
| ts_pcm | input | 8 | PCM byte of the requested slot |
| ts_sig | input | 4 | ABCD nibble of the requested slot (A in bit 3) |
| slot_req_o | output | 5 | Index of the slot whose data is loaded next |
| slot_load_o | output | 1 | Next rising edge captures ts_pcm / ts_sig |
| pcm_o | output | 1 | Serial PCM data |
| sig_o | output | 1 | Serial ABCD signaling data |
| fs_o | output | 1 | Frame sync pulse |
| mfs_o | output | 1 | Multiframe sync pulse |
| ts_ind_o | output | 1 | Timeslot indicator, first bit of each slot |
| sig_frz_o | output | 1 | Current slot's signaling is frozen |

## Verification
The hardest case to reach is a replay from the signaling store. It needs a full frame of live nibbles written first. The live pattern must then change so that replayed values can be told apart from live ones. The freeze request has to rise and fall in the middle of a slot, to show that it is sampled only at slot starts. The bench therefore runs whole frames with one pattern and then switches the pattern. It raises the freeze request at bit 4 of a slot, holds it across a frame wrap, and drops it at bit 6 of a later slot. A reference model of the store predicts every signaling bit. A long run of more than two multiframes checks the 48-frame marker spacing.

// File: rtl/tdm_rsb_pkg.sv
package tdm_rsb_pkg;

  typedef enum logic {
    LAUNCH_RISE = 1'b0,
    LAUNCH_FALL = 1'b1
  } launch_e;

  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/rsb_position_counter.sv
module rsb_position_counter #(
  parameter int NBIT   = 8,
  parameter int NSLOT  = 32,
  parameter int NFRAME = 48,
  localparam int BIT_W  = tdm_rsb_pkg::idx_width(NBIT),
  localparam int SLOT_W = tdm_rsb_pkg::idx_width(NSLOT),
  localparam int FRM_W  = tdm_rsb_pkg::idx_width(NFRAME)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [BIT_W-1:0]  bit_idx,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [FRM_W-1:0]  frame_idx,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic              first_bit,
  output logic              last_bit
);

  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(NBIT - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NSLOT - 1);
  localparam logic [FRM_W-1:0]  FRM_LAST  = FRM_W'(NFRAME - 1);

  assign first_bit = (bit_idx == '0);
  assign last_bit  = (bit_idx == BIT_LAST);
  assign nxt_slot  = (slot_idx == SLOT_LAST) ? '0 : slot_idx + 1'b1;

  // counters hold the position processed at the next rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx   <= '0;
      slot_idx  <= '0;
      frame_idx <= '0;
    end else if (last_bit) begin
      bit_idx  <= '0;
      slot_idx <= nxt_slot;
      if (slot_idx == SLOT_LAST) begin
        frame_idx <= (frame_idx == FRM_LAST) ? '0 : frame_idx + 1'b1;
      end
    end else begin
      bit_idx <= bit_idx + 1'b1;
    end
  end

endmodule

// File: rtl/rsb_sig_store.sv
module rsb_sig_store #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 4,
  localparam int AW = tdm_rsb_pkg::idx_width(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto block or distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
    if (rd_en) begin
      rd_data <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/rsb_edge_launch.sv
module rsb_edge_launch #(
  parameter int W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  tdm_rsb_pkg::launch_e   edge_sel,
  input  logic [W-1:0]           d_rise,
  output logic [W-1:0]           q
);

  for (genvar i = 0; i < W; i++) begin : g_lane
    logic q_fall;

    always_ff @(negedge clk) begin
      if (rst) q_fall <= 1'b0;
      else     q_fall <= d_rise[i];
    end

    assign q[i] = (edge_sel == tdm_rsb_pkg::LAUNCH_FALL) ? q_fall : d_rise[i];
  end

endmodule

// File: rtl/tdm_rx_serializer.sv
module tdm_rx_serializer #(
  parameter int PCM_W  = 8,
  parameter int SIG_W  = 4,
  parameter int NSLOT  = 32,
  parameter int NFRAME = 48,
  localparam int SLOT_W = tdm_rsb_pkg::idx_width(NSLOT),
  localparam int BIT_W  = tdm_rsb_pkg::idx_width(PCM_W),
  localparam int FRM_W  = tdm_rsb_pkg::idx_width(NFRAME)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_fall_edge,
  input  logic              freeze_in,
  input  logic [PCM_W-1:0]  ts_pcm,
  input  logic [SIG_W-1:0]  ts_sig,
  output logic [SLOT_W-1:0] slot_req_o,
  output logic              slot_load_o,
  output logic              pcm_o,
  output logic              sig_o,
  output logic              fs_o,
  output logic              mfs_o,
  output logic              ts_ind_o,
  output logic              sig_frz_o
);

  logic [BIT_W-1:0]  bit_idx;
  logic [SLOT_W-1:0] slot_idx;
  logic [FRM_W-1:0]  frame_idx;
  logic [SLOT_W-1:0] nxt_slot;
  logic              first_bit;
  logic              last_bit;

  rsb_position_counter #(
    .NBIT  (PCM_W),
    .NSLOT (NSLOT),
    .NFRAME(NFRAME)
  ) u_pos (
    .clk      (clk),
    .rst      (rst),
    .bit_idx  (bit_idx),
    .slot_idx (slot_idx),
    .frame_idx(frame_idx),
    .nxt_slot (nxt_slot),
    .first_bit(first_bit),
    .last_bit (last_bit)
  );

  // signaling store: written with live nibbles, read one bit ahead of each slot
  logic             st_wr;
  logic [SIG_W-1:0] st_rd_data;

  assign st_wr = !rst && first_bit && !freeze_in;

  rsb_sig_store #(
    .DEPTH(NSLOT),
    .WIDTH(SIG_W)
  ) u_store (
    .clk    (clk),
    .wr_en  (st_wr),
    .wr_addr(slot_idx),
    .wr_data(ts_sig),
    .rd_en  (last_bit),
    .rd_addr(nxt_slot),
    .rd_data(st_rd_data)
  );

  logic [SIG_W-1:0] abcd_pick;
  assign abcd_pick = freeze_in ? st_rd_data : ts_sig;

  // serial shifters and registered markers
  logic [PCM_W-1:0] pcm_sh;
  logic [SIG_W-1:0] abcd_rot;
  logic             pcm_r, sig_r, fs_r, mfs_r, ind_r, frz_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcm_sh   <= '0;
      abcd_rot <= '0;
      pcm_r    <= 1'b0;
      sig_r    <= 1'b0;
      fs_r     <= 1'b0;
      mfs_r    <= 1'b0;
      ind_r    <= 1'b0;
      frz_r    <= 1'b0;
    end else begin
      ind_r <= first_bit;
      fs_r  <= first_bit && (slot_idx == '0);
      mfs_r <= first_bit && (slot_idx == '0) && (frame_idx == '0);
      if (first_bit) begin
        pcm_r    <= ts_pcm[PCM_W-1];
        pcm_sh   <= {ts_pcm[PCM_W-2:0], 1'b0};
        sig_r    <= abcd_pick[SIG_W-1];
        abcd_rot <= {abcd_pick[SIG_W-2:0], abcd_pick[SIG_W-1]};
        frz_r    <= freeze_in;
      end else begin
        pcm_r    <= pcm_sh[PCM_W-1];
        pcm_sh   <= {pcm_sh[PCM_W-2:0], 1'b0};
        sig_r    <= abcd_rot[SIG_W-1];
        abcd_rot <= {abcd_rot[SIG_W-2:0], abcd_rot[SIG_W-1]};
      end
    end
  end

  // launch edge selection for the two data lanes
  tdm_rsb_pkg::launch_e edge_sel;
  logic [1:0]           lane_q;

  assign edge_sel = cfg_fall_edge ? tdm_rsb_pkg::LAUNCH_FALL : tdm_rsb_pkg::LAUNCH_RISE;

  rsb_edge_launch #(
    .W(2)
  ) u_launch (
    .clk     (clk),
    .rst     (rst),
    .edge_sel(edge_sel),
    .d_rise  ({pcm_r, sig_r}),
    .q       (lane_q)
  );

  assign pcm_o       = lane_q[1];
  assign sig_o       = lane_q[0];
  assign fs_o        = fs_r;
  assign mfs_o       = mfs_r;
  assign ts_ind_o    = ind_r;
  assign sig_frz_o   = frz_r;
  assign slot_req_o  = slot_idx;
  assign slot_load_o = first_bit;

endmodule

// File: rtl/rsb_checker.sv
module rsb_checker #(
  parameter int FRAME_CYC = 256,
  localparam int GW = $clog2(FRAME_CYC + 1)
) (
  input logic clk,
  input logic rst,
  input logic slot_load_o,
  input logic fs_o,
  input logic mfs_o,
  input logic ts_ind_o,
  input logic sig_frz_o
);

  logic          seen_fs;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_fs <= 1'b0;
      gap     <= '0;
    end else if (fs_o) begin
      seen_fs <= 1'b1;
      gap     <= '0;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    rst |=> (!fs_o && !mfs_o && !ts_ind_o && !sig_frz_o));

  a_r2_load_then_ind: assert property (@(posedge clk) disable iff (rst)
    slot_load_o |=> ts_ind_o);

  a_r3_ind_single: assert property (@(posedge clk) disable iff (rst)
    ts_ind_o |=> !ts_ind_o);

  a_r4_fs_on_ind: assert property (@(posedge clk) disable iff (rst)
    fs_o |-> ts_ind_o);

  a_r4_fs_period: assert property (@(posedge clk) disable iff (rst)
    (fs_o && seen_fs) |-> (gap == GW'(FRAME_CYC - 1)));

  a_r5_mfs_in_fs: assert property (@(posedge clk) disable iff (rst)
    mfs_o |-> fs_o);

  a_r8_frz_slot_stable: assert property (@(posedge clk) disable iff (rst)
    !ts_ind_o |-> $stable(sig_frz_o));

endmodule

bind tdm_rx_serializer rsb_checker #(
  .FRAME_CYC(NSLOT * PCM_W)
) u_rsb_chk (
  .clk        (clk),
  .rst        (rst),
  .slot_load_o(slot_load_o),
  .fs_o       (fs_o),
  .mfs_o      (mfs_o),
  .ts_ind_o   (ts_ind_o),
  .sig_frz_o  (sig_frz_o)
);

// File: tb/tdm_rx_serializer_test.sv
`timescale 1ns/1ps
module tdm_rx_serializer_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, cfg_fall, freeze;
  logic [7:0] ts_pcm;
  logic [3:0] ts_sig;
  logic [4:0] slot_req;
  logic       slot_load, pcm_o, sig_o, fs_o, mfs_o, ind_o, frz_o;

  tdm_rx_serializer uut (
    .clk          (clk),
    .rst          (rst),
    .cfg_fall_edge(cfg_fall),
    .freeze_in    (freeze),
    .ts_pcm       (ts_pcm),
    .ts_sig       (ts_sig),
    .slot_req_o   (slot_req),
    .slot_load_o  (slot_load),
    .pcm_o        (pcm_o),
    .sig_o        (sig_o),
    .fs_o         (fs_o),
    .mfs_o        (mfs_o),
    .ts_ind_o     (ind_o),
    .sig_frz_o    (frz_o)
  );

  int checks = 0;
  int fails  = 0;
  int n;
  int seed;
  int fs_seen, mfs_seen, frz_seen;

  logic [3:0] mem_m [32];
  logic [7:0] m_pcm;
  logic [3:0] m_abcd;
  logic       m_frz;
  logic       prev_pcm, prev_sig;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (pos %0d)", req, what, act, exp, n);
    end
  endtask

  function automatic logic [7:0] pat_pcm(input int s, input int sd);
    return 8'((s * 37 + sd * 11 + 5) & 255);
  endfunction

  function automatic logic [3:0] pat_sig(input int s, input int sd);
    return 4'((s * 3 + sd * 5 + 1) & 15);
  endfunction

  task automatic drive_next();
    int s;
    s = (n / 8) % 32;
    ts_pcm = pat_pcm(s, seed);
    ts_sig = pat_sig(s, seed);
  endtask

  // one clock: model position n, compare at 1 ns after the rising edge
  task automatic step();
    int  b, s, f;
    bit  e_pcm, e_sig, e_fs, e_mfs, e_ind;
    b = n % 8;
    s = (n / 8) % 32;
    f = (n / 256) % 48;
    if (b == 0) begin
      chk(slot_load === 1'b1 && slot_req === 5'(s), "R2", "slot request",
          int'(slot_req), s);
      m_pcm = ts_pcm;
      if (freeze) begin
        m_abcd = mem_m[s];
        m_frz  = 1'b1;
      end else begin
        m_abcd   = ts_sig;
        mem_m[s] = ts_sig;
        m_frz    = 1'b0;
      end
    end
    e_pcm = m_pcm[7 - b];
    e_sig = m_abcd[3 - (b % 4)];
    e_ind = (b == 0);
    e_fs  = e_ind && (s == 0);
    e_mfs = e_fs && (f == 0);
    @(posedge clk);
    #1;
    if (!cfg_fall) begin
      chk(pcm_o === e_pcm, "R2", "pcm bit", int'(pcm_o), int'(e_pcm));
      chk(sig_o === e_sig, m_frz ? "R7" : "R6", "sig bit", int'(sig_o), int'(e_sig));
    end else begin
      chk(pcm_o === prev_pcm, "R9", "pcm bit fall", int'(pcm_o), int'(prev_pcm));
      chk(sig_o === prev_sig, "R9", "sig bit fall", int'(sig_o), int'(prev_sig));
    end
    chk(ind_o === e_ind, "R3", "timeslot indicator", int'(ind_o), int'(e_ind));
    chk(fs_o === e_fs, "R4", "frame sync", int'(fs_o), int'(e_fs));
    chk(mfs_o === e_mfs, "R5", "multiframe sync", int'(mfs_o), int'(e_mfs));
    chk(frz_o === m_frz, "R8", "freeze flag", int'(frz_o), int'(m_frz));
    if (fs_o === 1'b1)  fs_seen++;
    if (mfs_o === 1'b1) mfs_seen++;
    if (frz_o === 1'b1) frz_seen++;
    prev_pcm = e_pcm;
    prev_sig = e_sig;
    n++;
    drive_next();
  endtask

  task automatic run_until_bit(input int bit_pos);
    while ((n % 8) != bit_pos) step();
  endtask

  task automatic t_reset();
    rst    = 1'b1;
    freeze = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(fs_o === 1'b0, "R1", "fs in reset", int'(fs_o), 0);
    chk(mfs_o === 1'b0, "R1", "mfs in reset", int'(mfs_o), 0);
    chk(ind_o === 1'b0, "R1", "ind in reset", int'(ind_o), 0);
    chk(frz_o === 1'b0, "R1", "frz in reset", int'(frz_o), 0);
    chk(pcm_o === 1'b0 && sig_o === 1'b0, "R1", "data in reset",
        int'({pcm_o, sig_o}), 0);
    rst      = 1'b0;
    n        = 0;
    prev_pcm = 1'b0;
    prev_sig = 1'b0;
    m_pcm    = '0;
    m_abcd   = '0;
    m_frz    = 1'b0;
    drive_next();
  endtask

  task automatic t_start();
    logic [7:0] first_byte;
    first_byte = ts_pcm;
    step();
    chk(fs_o === 1'b1 && mfs_o === 1'b1 && ind_o === 1'b1, "R10", "first edge markers",
        int'({fs_o, mfs_o, ind_o}), 7);
    chk(pcm_o === first_byte[7], "R10", "first pcm bit", int'(pcm_o), int'(first_byte[7]));
  endtask

  task automatic t_rise_frames();
    int fs0;
    fs0  = fs_seen;
    seed = 1;
    repeat (300) step();
    seed = 2;
    repeat (212) step();
    chk(fs_seen - fs0 == 2, "R4", "frame pulses in 512 clocks", fs_seen - fs0, 2);
  endtask

  task automatic t_freeze();
    int f0;
    f0   = frz_seen;
    seed = 3;
    repeat (256) step();
    run_until_bit(4);
    freeze = 1'b1;
    seed   = 4;
    step();
    chk(frz_o === 1'b0, "R7", "mid-slot freeze ignored", int'(frz_o), 0);
    run_until_bit(0);
    repeat (300) step();
    run_until_bit(6);
    freeze = 1'b0;
    step();
    chk(frz_o === 1'b1, "R8", "mid-slot release ignored", int'(frz_o), 1);
    repeat (300) step();
    chk(frz_seen - f0 > 256, "R8", "frozen clocks seen", frz_seen - f0, 257);
  endtask

  task automatic t_fall_edge();
    cfg_fall = 1'b1;
    seed     = 5;
    repeat (256) step();
    @(negedge clk);
    #1;
    chk(pcm_o === prev_pcm, "R9", "pcm after falling edge", int'(pcm_o), int'(prev_pcm));
    cfg_fall = 1'b0;
    @(posedge clk);
    #1;
    chk(1'b1, "R9", "realign", 0, 0);
    n++;
    drive_next();
    repeat (20) step();
  endtask

  task automatic t_multiframe();
    int m0, target, exp_cnt;
    m0      = mfs_seen;
    exp_cnt = 0;
    target  = 2 * 12288 + 1;
    for (int p = n; p < target; p++) begin
      if (p % 12288 == 0) exp_cnt++;
    end
    seed = 6;
    while (n < target) step();
    chk(mfs_seen - m0 == exp_cnt, "R5", "multiframe pulses", mfs_seen - m0, exp_cnt);
  endtask

  initial begin
    rst      = 1'b1;
    cfg_fall = 1'b0;
    freeze   = 1'b0;
    ts_pcm   = '0;
    ts_sig   = '0;
    seed     = 0;
    fs_seen  = 0;
    mfs_seen = 0;
    frz_seen = 0;
    n        = 0;
    t_reset();
    t_start();
    t_rise_frames();
    t_freeze();
    t_fall_edge();
    t_multiframe();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule